// File: doc/BRIEF.md
# Core Clock Source Divider

This block makes the core clock timing for an audio subsystem. Two source clocks reach it as qualified single-cycle tick strobes in the system clock domain. One strobe comes from the external master clock input and the other from the PLL output. A small control register chooses the source, declares the ratio of the source to the base sample rate fs, and turns the core clock on or off. The block counts ticks of the chosen source and divides by 1, 2, 3 or 4, so that the resulting core clock enable runs at 256×fs.

The PLL always runs at 1024×fs, so selecting it forces a divide by 4, whatever the ratio field holds. The core clock is issued as a one-cycle enable pulse, `core_tick`. The duty cycle is not 50%, and every ratio, including divide by 3, gives an exact period measured in source ticks. Any change of source, ratio or enable restarts the divider at zero. This keeps a short first period from appearing after a change. Register reads return the effective configuration.

Top module: `core_clk_div`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `core_tick` is low, with the core clock disabled, the external master clock selected and the ratio code 00.
- R2: Bit 3 of the control register selects the tick source: 0 counts `mclk_tick` and 1 counts `pll_tick`. Ticks on the unselected input have no effect on `core_tick`.
- R3: With the external source selected, ratio code bits [2:1] set the division: 00 divides by 1, 01 by 2, 10 by 3 and 11 by 4. `core_tick` pulses once for every that many selected ticks.
- R4: With the PLL selected, the division is 4 whatever the stored ratio code.
- R5: Bit 0 enables the core clock. While it is 0, `core_tick` stays low and the tick count is held at zero.
- R6: `core_tick` is a single-cycle pulse. It appears in the cycle after the clock edge that samples the selected tick that completes a period.
- R7: A write that changes bit 3, bits [2:1] or bit 0 clears the tick count. A tick sampled in the same cycle as that write is not counted, and the next pulse needs a full new period.
- R8: `rd_data` bits [7:4] always read 0, whatever was written to them. With the PLL selected, bits [2:1] read 11.
- R9: A write that leaves bits [3:0] unchanged does not disturb the tick count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Effective control register value |
| mclk_tick | input | 1 | Qualified tick from the external master clock |
| pll_tick | input | 1 | Qualified tick from the PLL output |
| core_tick | output | 1 | Core clock enable pulse at 256×fs |

## Verification
The assertions check on every cycle that:
- reserved read bits are zero and a PLL selection reads back ratio 11;
- each pulse was caused by an enabled tick from the selected source;
- no pulse appears in a cycle where the configuration read-back changed;
- pulses under the PLL source are at least four cycles apart.

Only the bench scenarios can show the exact pulse count for each ratio, the placement of pulses within sparse tick patterns, the restart after changes made in the middle of a period, and the absence of any disturbance from same-value writes. These scenarios are compared against the reference model on every clock.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int MAX_DIV = 4;
    localparam int CNT_W   = $clog2(MAX_DIV);
    localparam int N_SRC   = 2;

    typedef struct packed {
        logic       src;    // 0: external master clock, 1: PLL
        logic [1:0] ratio;  // source rate / 256fs, minus one
        logic       en;
    } ccd_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } ccd_div_t;
endpackage

// File: rtl/ccd_ctrl_reg.sv
module ccd_ctrl_reg
    import ccd_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ccd_cfg_t         cfg_o,
    output logic [CNT_W-1:0] div_m1_o,
    output logic             changed_o,
    output logic [REG_W-1:0] rd_data_o
);
    localparam int CFG_W = $bits(ccd_cfg_t);

    ccd_cfg_t cfg_d, cfg_q;
    ccd_cfg_t wr_cfg;

    always_comb begin
        wr_cfg    = ccd_cfg_t'(wr_data[CFG_W-1:0]);
        cfg_d     = cfg_q;
        changed_o = wr_en && (wr_cfg != cfg_q);
        if (wr_en) cfg_d = wr_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // PLL runs at the top ratio, so the effective divide is forced to max
    always_comb begin
        div_m1_o = cfg_q.src ? CNT_W'(MAX_DIV - 1) : cfg_q.ratio;
        rd_data_o = '0;
        rd_data_o[CFG_W-1:0] = {cfg_q.src, div_m1_o, cfg_q.en};
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/ccd_src_mux.sv
module ccd_src_mux
    import ccd_pkg::*;
(
    input  logic [N_SRC-1:0]         ticks,
    input  logic [$clog2(N_SRC)-1:0] sel,
    output logic                     tick_o
);
    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == i[$clog2(N_SRC)-1:0]) tick_o = ticks[i];
        end
    end
endmodule

// File: rtl/ccd_div.sv
module ccd_div
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    input  logic [CNT_W-1:0] div_m1,
    output logic             pulse_o
);
    ccd_div_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clear || !en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == div_m1) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/core_clk_div.sv
module core_clk_div
    import ccd_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             mclk_tick,
    input  logic             pll_tick,
    output logic             core_tick
);
    ccd_cfg_t         cfg;
    logic [CNT_W-1:0] div_m1;
    logic             changed;
    logic             sel_tick;

    ccd_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg_o     (cfg),
        .div_m1_o  (div_m1),
        .changed_o (changed),
        .rd_data_o (rd_data)
    );

    ccd_src_mux u_mux (
        .ticks  ({pll_tick, mclk_tick}),
        .sel    (cfg.src),
        .tick_o (sel_tick)
    );

    ccd_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sel_tick),
        .en      (cfg.en),
        .clear   (changed),
        .div_m1  (div_m1),
        .pulse_o (core_tick)
    );
endmodule

// File: rtl/core_clk_div_chk.sv
module core_clk_div_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             mclk_tick,
    input logic             pll_tick,
    input logic             core_tick
);
    logic [2:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (core_tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 3'd7) begin
            gap_q  <= gap_q + 3'd1;
        end
    end

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:4] == '0);

    assert_pll_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> rd_data[2:1] == 2'b11);

    assert_enabled_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> $past(rd_data[0] && (rd_data[3] ? pll_tick : mclk_tick)));

    assert_src_pll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_tick && $past(rd_data[3])) |-> $past(pll_tick));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> !core_tick);

    assert_pll_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_tick && rd_data[3] && seen_q) |-> gap_q >= 3'd3);
endmodule

bind core_clk_div core_clk_div_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .mclk_tick (mclk_tick),
    .pll_tick  (pll_tick),
    .core_tick (core_tick)
);

// File: tb/tb_core_clk_div.sv
module tb_core_clk_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mclk_tick = 1'b0;
    logic       pll_tick = 1'b0;
    logic [7:0] rd_data;
    logic       core_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses = 0;
    string req = "R1";

    // behavioural reference state
    int m_src = 0, m_ratio = 0, m_en = 0, m_cnt = 0, m_core = 0;

    core_clk_div dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mclk_tick(mclk_tick), .pll_tick(pll_tick),
        .core_tick(core_tick)
    );

    always #10 clk = ~clk;

    function automatic int exp_rd();
        return (m_src << 3) | ((m_src != 0 ? 3 : m_ratio) << 1) | m_en;
    endfunction

    task automatic model_edge();
        int nv_src, nv_ratio, nv_en, tk, dv;
        if (!rst_n) begin
            m_src = 0; m_ratio = 0; m_en = 0; m_cnt = 0; m_core = 0;
            return;
        end
        m_core = 0;
        if (wr_en) begin
            nv_src = wr_data[3]; nv_ratio = wr_data[2:1]; nv_en = wr_data[0];
            if (nv_src != m_src || nv_ratio != m_ratio || nv_en != m_en) begin
                m_src = nv_src; m_ratio = nv_ratio; m_en = nv_en; m_cnt = 0;
                return;
            end
        end
        if (m_en == 0) begin
            m_cnt = 0;
            return;
        end
        tk = (m_src != 0) ? pll_tick : mclk_tick;
        dv = (m_src != 0) ? 4 : m_ratio + 1;
        if (tk != 0) begin
            m_cnt++;
            if (m_cnt == dv) begin
                m_cnt = 0;
                m_core = 1;
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (core_tick !== m_core[0]) begin
            errors++;
            $display("FAIL %s core_tick actual=%0b expected=%0d t=%0t", req, core_tick, m_core, $time);
        end
        checks++;
        if (rd_data !== 8'(exp_rd())) begin
            errors++;
            $display("FAIL %s rd_data actual=%02h expected=%02h t=%0t", req, rd_data, exp_rd(), $time);
        end
        if (core_tick === 1'b1) pulses++;
    endtask

    // called at a negedge: drive, take the edge, compare at the next negedge
    task automatic step(input logic w, input logic [7:0] d, input logic m, input logic p);
        wr_en = w; wr_data = d; mclk_tick = m; pll_tick = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0;
        compare();
    endtask

    task automatic run(input int n, input int mper, input int pper);
        for (int i = 0; i < n; i++)
            step(1'b0, 8'h00, (mper > 0) && (i % mper == 0), (pper > 0) && (i % pper == 0));
    endtask

    task automatic expect_pulses(input int exp, input string tag);
        checks++;
        if (pulses != exp) begin
            errors++;
            $display("FAIL %s pulse count actual=%0d expected=%0d", tag, pulses, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        rst_n = 1'b1;
        req = "R1";
        step(1'b0, 8'h00, 1'b1, 1'b1);   // reset state, disabled: no pulses (R1, R5)

        req = "R3 div1";
        step(1'b1, 8'h01, 1'b0, 1'b0);
        pulses = 0;
        run(12, 1, 0);
        expect_pulses(12, "R3 div1");

        req = "R3 div2";
        step(1'b1, 8'h03, 1'b0, 1'b0);
        pulses = 0;
        run(24, 2, 0);
        expect_pulses(6, "R3 div2");

        req = "R3 div3";
        step(1'b1, 8'h05, 1'b0, 1'b0);
        pulses = 0;
        run(36, 1, 0);
        expect_pulses(12, "R3 div3");

        req = "R3 div4";
        step(1'b1, 8'h07, 1'b0, 1'b0);
        pulses = 0;
        run(40, 3, 0);   // 14 ticks -> 3 pulses
        expect_pulses(3, "R3 div4");

        req = "R2 unselected pll";
        step(1'b1, 8'h01, 1'b0, 1'b0);
        pulses = 0;
        run(20, 0, 1);
        expect_pulses(0, "R2 unselected pll");

        req = "R4 pll forced div4";
        step(1'b1, 8'h09, 1'b0, 1'b0);   // ratio field 00 but PLL selected
        pulses = 0;
        run(32, 1, 1);
        expect_pulses(8, "R4 pll forced div4");

        req = "R2 unselected mclk";
        pulses = 0;
        run(16, 1, 0);
        expect_pulses(0, "R2 unselected mclk");

        req = "R8 reserved bits";
        step(1'b1, 8'hF3, 1'b0, 1'b0);   // reads back 0x03
        run(6, 2, 0);

        req = "R5 disabled";
        step(1'b1, 8'h06, 1'b0, 1'b0);
        pulses = 0;
        run(20, 1, 1);
        expect_pulses(0, "R5 disabled");

        req = "R7 restart on change";
        step(1'b1, 8'h07, 1'b0, 1'b0);
        run(3, 1, 0);                      // count at 3 of 4
        step(1'b1, 8'h05, 1'b1, 1'b0);    // change, tick ignored
        pulses = 0;
        run(2, 1, 0);
        expect_pulses(0, "R7 restart on change");
        run(1, 1, 0);
        expect_pulses(1, "R7 restart on change");

        req = "R9 same-value write";
        run(2, 1, 0);                      // count at 2 of 3
        step(1'b1, 8'h05, 1'b1, 1'b0);    // same config, tick counts
        expect_pulses(2, "R9 same-value write");

        req = "R7 pll ratio change";
        step(1'b1, 8'h0F, 1'b0, 1'b0);
        run(3, 0, 1);
        step(1'b1, 8'h09, 1'b0, 1'b1);    // stored ratio changes: restart
        pulses = 0;
        run(3, 0, 1);
        expect_pulses(0, "R7 pll ratio change");
        run(1, 0, 1);
        expect_pulses(1, "R7 pll ratio change");

        req = "R6 sparse ticks";
        step(1'b1, 8'h03, 1'b0, 1'b0);
        run(30, 5, 7);

        req = "R1 reset again";
        rst_n = 1'b0;
        step(1'b0, 8'h00, 1'b1, 1'b1);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule